// File: doc/BRIEF.md
# Two-wire EEPROM slave protocol engine

This block is the bus-facing half of a byte-addressed nonvolatile memory model that hangs on a two-wire serial bus. It runs on a fast system clock and oversamples the bus clock and data lines. From those samples it detects bus start and stop events and shifts in the addressing byte and two word-address bytes. It acknowledges by pulling the data line low through an open-drain enable, and it shifts read data back out.

The block keeps a 16-bit pointer that survives between transactions. That pointer serves current-address reads, random reads (a write that carries only the address, then a repeated start) and sequential reads. Each received data byte goes to a separate page-write engine as a one-cycle strobe with its address, and a stop that closes such a write is reported on its own strobe. Array data comes in through a synchronous read port: a request on `rdEn`/`rdAddr` is answered on `rdData` on the next clock. While the page-write engine reports `busy`, the block stays off the bus. A host can therefore poll for the end of the write cycle by sending the address byte until it is acknowledged.

Top module: `tws_slave`

## Requirements
- R1: A falling data line while the bus clock is high is a start. A start in any state, including the middle of a byte, abandons the transfer in progress and begins a new address-byte phase. A rising data line while the bus clock is high is a stop. A stop returns the block to idle, and within three system clocks of the stop reaching the pins the data line is released (`sdaOe` = 0).
- R2: The first byte after a start is taken most significant bit first. It is accepted when bits 7..4 are 1010 and bits 3..1 equal `strap[2:0]`. Bit 0 selects the direction: 1 = read, 0 = write. On acceptance the block holds the data line low for the whole ninth clock.
- R3: If the first byte does not match, the block gives no acknowledge and ignores all further clocks until the next start.
- R4: In a write, the block takes two word-address bytes, high byte first, and then any number of data bytes, acknowledging each one. Every data byte appears as a one-cycle `wrValid` pulse carrying `wrData` and its address on `wrAddr`.
- R5: Between written bytes, only the low 7 address bits count up. They wrap from the top of a 128-byte page to its first byte, and the upper bits stay fixed.
- R6: `wrStop` pulses for one cycle at a stop that ends a write in which at least one data byte was taken. A write that loaded only the address, and any read, ends with no pulse.
- R7: The pointer holds the last address accessed plus one and persists between transactions. A read that starts straight after the address byte returns the byte at that pointer.
- R8: A random read (write address byte, two word-address bytes, repeated start, read address byte) returns the byte at the loaded address.
- R9: During a read, the block sends the next byte each time the host acknowledges. After a host no-acknowledge it releases the data line and ignores further clocks until a start.
- R10: During reads the pointer counts over the full 16-bit range, wrapping from 0xFFFF to 0x0000.
- R11: While `busy` is high, the block releases the data line within one cycle and acknowledges nothing. Once `busy` falls, it responds to its address again.
- R12: The block drives the data line low (`sdaOe` rising) only while the bus clock is low, never while it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Bus clock line as seen at the pin |
| sdaIn | input | 1 | Bus data line as seen at the pin (wired level) |
| strap | input | 3 | Board-strapped address bits compared with bits 3..1 of the address byte |
| busy | input | 1 | High while the page-write engine runs its internal write cycle |
| rdData | input | 8 | Array data, valid the cycle after `rdEn` |
| sdaOe | output | 1 | Open-drain enable; 1 pulls the data line low |
| rdEn | output | 1 | Array read request strobe |
| rdAddr | output | 16 | Array read address |
| wrValid | output | 1 | One-cycle strobe for a received data byte |
| wrAddr | output | 16 | Target address of the received byte |
| wrData | output | 8 | Received data byte |
| wrStop | output | 1 | One-cycle strobe: stop closed a write carrying data |

## Verification
The assertions check on every cycle that a stop seen at the pins releases the data line three clocks later and that `busy` forces the line free. They also check that the line is only pulled low after the bus clock has gone low, and that the write, stop and read strobes last a single cycle and never overlap. Only the bench scenarios can show what is carried in the bytes: that the address byte and strap comparison pick the right response, and that the pointer persists and points where it should. Page wrap on writes, full-range wrap on reads, and recovery from a start in the middle of a byte are likewise shown only by the bench.

// File: rtl/tws_pkg.sv
package tws_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_DEV,
    PH_ADRH,
    PH_ADRL,
    PH_WDAT,
    PH_RDAT
  } phase_t;

  // strobes from control to datapath
  typedef struct packed {
    logic shiftIn;
    logic ackDrive;
    logic lineFree;
    logic loadHi;
    logic loadLo;
    logic wrByte;
    logic ptrInc;
    logic ptrIncPage;
    logic rdReq;
    logic shiftOut;
  } strobe_t;

  // bus events from datapath to control
  typedef struct packed {
    logic sclRise;
    logic sclFall;
    logic startDet;
    logic stopDet;
    logic sdaBit;
  } busStat_t;

endpackage

// File: rtl/tws_sync.sv
module tws_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] pipe;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) pipe <= '1;
        else       pipe <= d;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) pipe <= '1;
        else       pipe <= {pipe[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/tws_dp.sv
module tws_dp
  import tws_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int PAGE_BITS   = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  strobe_t           stb,
  input  logic [7:0]        rdData,
  output busStat_t          stat,
  output logic [7:0]        rxByte,
  output logic              sdaOe,
  output logic              rdEn,
  output logic [ADDR_W-1:0] rdAddr,
  output logic              wrValid,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [7:0]        wrData
);
  localparam int HI_W = ADDR_W - 8;
  localparam logic [ADDR_W-1:0]    ADDR_ONE = 1;
  localparam logic [PAGE_BITS-1:0] PAGE_ONE = 1;

  logic sclS, sdaS, sclD, sdaD;
  logic [ADDR_W-1:0] ptr, ptrNext, ptrNextPage;
  logic [7:0] txReg;
  logic rdPend;

  tws_sync #(.STAGES(SYNC_STAGES)) u_sclSync (.clk(clk), .rstN(rstN), .d(sclIn), .q(sclS));
  tws_sync #(.STAGES(SYNC_STAGES)) u_sdaSync (.clk(clk), .rstN(rstN), .d(sdaIn), .q(sdaS));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclD <= 1'b1;
      sdaD <= 1'b1;
    end else begin
      sclD <= sclS;
      sdaD <= sdaS;
    end
  end

  always_comb begin
    stat.sclRise  = sclS & ~sclD;
    stat.sclFall  = ~sclS & sclD;
    stat.startDet = sclS & sclD & sdaD & ~sdaS;
    stat.stopDet  = sclS & sclD & ~sdaD & sdaS;
    stat.sdaBit   = sdaS;
  end

  assign ptrNext     = ptr + ADDR_ONE;
  assign ptrNextPage = {ptr[ADDR_W-1:PAGE_BITS], ptr[PAGE_BITS-1:0] + PAGE_ONE};

  // receive shifter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           rxByte <= '0;
    else if (stb.shiftIn) rxByte <= {rxByte[6:0], sdaS};
  end

  // address pointer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr <= '0;
    end else begin
      if (stb.loadHi)     ptr[ADDR_W-1:8] <= rxByte[HI_W-1:0];
      if (stb.loadLo)     ptr[7:0]        <= rxByte;
      if (stb.ptrIncPage) ptr             <= ptrNextPage;
      else if (stb.ptrInc) ptr            <= ptrNext;
    end
  end

  // write byte hand-off
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrValid <= 1'b0;
      wrAddr  <= '0;
      wrData  <= '0;
    end else begin
      wrValid <= stb.wrByte;
      if (stb.wrByte) begin
        wrAddr <= ptr;
        wrData <= rxByte;
      end
    end
  end

  // array read request, data lands one cycle later
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdEn   <= 1'b0;
      rdAddr <= '0;
      rdPend <= 1'b0;
    end else begin
      rdEn   <= stb.rdReq;
      rdPend <= rdEn;
      if (stb.rdReq) rdAddr <= stb.ptrInc ? ptrNext : ptr;
    end
  end

  // open-drain output and transmit shifter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sdaOe <= 1'b0;
      txReg <= 8'hFF;
    end else if (stb.shiftOut) begin
      sdaOe <= ~txReg[7];
      txReg <= {txReg[6:0], 1'b1};
    end else begin
      if (rdPend) txReg <= rdData;
      if (stb.lineFree)      sdaOe <= 1'b0;
      else if (stb.ackDrive) sdaOe <= 1'b1;
    end
  end
endmodule

// File: rtl/tws_ctrl.sv
module tws_ctrl
  import tws_pkg::*;
#(
  parameter logic [3:0] DEV_PREFIX = 4'b1010,
  parameter int         STRAP_W    = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  busStat_t           stat,
  input  logic [7:0]         rxByte,
  input  logic [STRAP_W-1:0] strap,
  input  logic               busy,
  output strobe_t            stb,
  output logic               wrStop
);
  localparam logic [3:0] BITS_DONE = 4'd8;
  localparam logic [3:0] ACK_SLOT  = 4'd9;

  phase_t     phase, phaseN;
  logic [3:0] cnt, cntN;
  logic       mAck, mAckN;
  logic       wrAny, wrAnyN;
  logic       devHit;

  assign devHit = (rxByte[7:4] == DEV_PREFIX) && (rxByte[3:1] == strap);

  always_comb begin
    stb    = '0;
    phaseN = phase;
    cntN   = cnt;
    mAckN  = mAck;
    wrAnyN = wrAny;
    if (busy) begin
      phaseN       = PH_IDLE;
      cntN         = '0;
      wrAnyN       = 1'b0;
      stb.lineFree = 1'b1;
    end else if (stat.startDet) begin
      phaseN       = PH_DEV;
      cntN         = '0;
      wrAnyN       = 1'b0;
      stb.lineFree = 1'b1;
    end else if (stat.stopDet) begin
      phaseN       = PH_IDLE;
      cntN         = '0;
      wrAnyN       = 1'b0;
      stb.lineFree = 1'b1;
    end else begin
      case (phase)
        PH_IDLE: ;
        PH_RDAT: begin
          if (stat.sclFall) begin
            if (cnt < BITS_DONE) begin
              stb.shiftOut = 1'b1;
              cntN         = cnt + 4'd1;
            end else if (cnt == BITS_DONE) begin
              stb.lineFree = 1'b1;
              stb.ptrInc   = 1'b1;
              stb.rdReq    = 1'b1;
              cntN         = ACK_SLOT;
            end else if (mAck) begin
              stb.shiftOut = 1'b1;
              cntN         = 4'd1;
            end else begin
              phaseN = PH_IDLE;
              cntN   = '0;
            end
          end else if (stat.sclRise && cnt == ACK_SLOT) begin
            mAckN = ~stat.sdaBit;
          end
        end
        default: begin
          if (stat.sclRise && cnt < BITS_DONE) begin
            stb.shiftIn = 1'b1;
            cntN        = cnt + 4'd1;
          end else if (stat.sclFall && cnt == BITS_DONE) begin
            if (phase == PH_DEV && !devHit) begin
              phaseN = PH_IDLE;
              cntN   = '0;
            end else begin
              stb.ackDrive = 1'b1;
              cntN         = ACK_SLOT;
              case (phase)
                PH_DEV:  stb.rdReq  = rxByte[0];
                PH_ADRH: stb.loadHi = 1'b1;
                PH_ADRL: stb.loadLo = 1'b1;
                PH_WDAT: begin
                  stb.wrByte     = 1'b1;
                  stb.ptrIncPage = 1'b1;
                  wrAnyN         = 1'b1;
                end
                default: ;
              endcase
            end
          end else if (stat.sclFall && cnt == ACK_SLOT) begin
            cntN = '0;
            if (phase == PH_DEV && rxByte[0]) begin
              phaseN       = PH_RDAT;
              stb.shiftOut = 1'b1;
              cntN         = 4'd1;
            end else begin
              stb.lineFree = 1'b1;
              case (phase)
                PH_DEV:  phaseN = PH_ADRH;
                PH_ADRH: phaseN = PH_ADRL;
                default: phaseN = PH_WDAT;
              endcase
            end
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase  <= PH_IDLE;
      cnt    <= '0;
      mAck   <= 1'b0;
      wrAny  <= 1'b0;
      wrStop <= 1'b0;
    end else begin
      phase  <= phaseN;
      cnt    <= cntN;
      mAck   <= mAckN;
      wrAny  <= wrAnyN;
      wrStop <= !busy && !stat.startDet && stat.stopDet && wrAny;
    end
  end
endmodule

// File: rtl/tws_slave.sv
module tws_slave
  import tws_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int PAGE_BITS   = 7,
  parameter int SYNC_STAGES = 2,
  parameter int STRAP_W     = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sclIn,
  input  logic               sdaIn,
  input  logic [STRAP_W-1:0] strap,
  input  logic               busy,
  input  logic [7:0]         rdData,
  output logic               sdaOe,
  output logic               rdEn,
  output logic [ADDR_W-1:0]  rdAddr,
  output logic               wrValid,
  output logic [ADDR_W-1:0]  wrAddr,
  output logic [7:0]         wrData,
  output logic               wrStop
);
  strobe_t    stb;
  busStat_t   stat;
  logic [7:0] rxByte;

  tws_ctrl #(.STRAP_W(STRAP_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .stat(stat), .rxByte(rxByte),
    .strap(strap), .busy(busy), .stb(stb), .wrStop(wrStop)
  );

  tws_dp #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .stb(stb),
    .rdData(rdData), .stat(stat), .rxByte(rxByte), .sdaOe(sdaOe),
    .rdEn(rdEn), .rdAddr(rdAddr), .wrValid(wrValid), .wrAddr(wrAddr),
    .wrData(wrData)
  );
endmodule

// File: rtl/tws_checker.sv
module tws_checker (
  input logic clk,
  input logic rstN,
  input logic sclIn,
  input logic sdaIn,
  input logic busy,
  input logic sdaOe,
  input logic rdEn,
  input logic wrValid,
  input logic wrStop
);
  AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rstN)
    (sclIn && $past(sclIn) && sdaIn && !$past(sdaIn)) |-> ##3 !sdaOe); // R1

  AST_DRIVE_ON_LOW_SCL: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaOe) |-> !$past(sclIn, 3)); // R12

  AST_BUSY_FREES_LINE: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> !sdaOe); // R11

  AST_WR_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    wrValid |=> !wrValid); // R4

  AST_STOP_NOT_WITH_BYTE: assert property (@(posedge clk) disable iff (!rstN)
    !(wrStop && wrValid)); // R6

  AST_STOP_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    wrStop |=> !wrStop); // R6

  AST_RD_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    rdEn |=> !rdEn); // R9
endmodule

bind tws_slave tws_checker u_tws_checker (
  .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .busy(busy),
  .sdaOe(sdaOe), .rdEn(rdEn), .wrValid(wrValid), .wrStop(wrStop)
);

// File: tb/tws_slave_bench.sv
module tws_slave_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 8;
  localparam logic [2:0] STRAP = 3'b101;
  localparam logic [7:0] DEV_W = 8'hAA;
  localparam logic [7:0] DEV_R = 8'hAB;
  // {address, byte count} per random/sequential read
  localparam logic [19:0] RD_TABLE [0:4] = '{20'h00403, 20'hFFFE3, 20'h12341, 20'h00FF2, 20'hA5A54};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1;
  logic sdaM = 1'b1;
  logic busy = 1'b0;
  logic [7:0] rdData = '0;
  logic sdaOe, rdEn, wrValid, wrStop;
  logic [15:0] rdAddr, wrAddr;
  logic [7:0] wrData;
  logic sdaBus;

  int nChecks = 0;
  int nFail = 0;
  int wrCnt = 0;
  int stopCnt = 0;
  int oeHighViol = 0;
  logic prevOe = 1'b0;
  logic [15:0] logAddr [0:31];
  logic [7:0]  logData [0:31];

  assign sdaBus = sdaM & ~sdaOe;

  always #(CLK_PERIOD/2) clk = ~clk;

  tws_slave u_tws_slave (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaBus), .strap(STRAP),
    .busy(busy), .rdData(rdData), .sdaOe(sdaOe), .rdEn(rdEn), .rdAddr(rdAddr),
    .wrValid(wrValid), .wrAddr(wrAddr), .wrData(wrData), .wrStop(wrStop)
  );

  function automatic logic [7:0] memByte(input logic [15:0] a);
    return (a[7:0] * 8'd3) ^ a[15:8] ^ 8'hA5;
  endfunction

  always @(posedge clk) if (rdEn) rdData <= memByte(rdAddr);

  always @(negedge clk) begin
    if (wrValid && wrCnt < 32) begin
      logAddr[wrCnt] = wrAddr;
      logData[wrCnt] = wrData;
    end
    if (wrValid) wrCnt++;
    if (wrStop) stopCnt++;
    if (sdaOe && !prevOe && sclM) oeHighViol++;
    prevOe = sdaOe;
  end

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic halfWait();
    repeat (HALF) @(negedge clk);
  endtask

  task automatic busStart();
    sdaM = 1'b1; halfWait();
    sclM = 1'b1; halfWait();
    sdaM = 1'b0; halfWait();
    sclM = 1'b0; @(negedge clk);
  endtask

  task automatic busStop();
    sdaM = 1'b0; halfWait();
    sclM = 1'b1; halfWait();
    sdaM = 1'b1; halfWait();
  endtask

  task automatic sendBits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sdaM = b[i]; halfWait();
      sclM = 1'b1; halfWait();
      sclM = 1'b0; @(negedge clk);
    end
  endtask

  task automatic sendByte(input logic [7:0] b, output logic acked);
    sendBits(b, 8);
    sdaM = 1'b1; halfWait();
    sclM = 1'b1; repeat (HALF/2) @(negedge clk);
    acked = !sdaBus;
    repeat (HALF - HALF/2) @(negedge clk);
    sclM = 1'b0; @(negedge clk);
  endtask

  task automatic recvByte(input logic hostAck, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      halfWait();
      sclM = 1'b1; repeat (HALF/2) @(negedge clk);
      b[i] = sdaBus;
      repeat (HALF - HALF/2) @(negedge clk);
      sclM = 1'b0; @(negedge clk);
    end
    sdaM = hostAck ? 1'b0 : 1'b1; halfWait();
    sclM = 1'b1; halfWait();
    sclM = 1'b0; @(negedge clk);
    sdaM = 1'b1;
  endtask

  task automatic spareClock(output logic level);
    halfWait();
    sclM = 1'b1; repeat (HALF/2) @(negedge clk);
    level = sdaBus;
    repeat (HALF - HALF/2) @(negedge clk);
    sclM = 1'b0; @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finishRun();
  end

  initial begin
    logic ack;
    logic [7:0] b;
    logic lvl;
    int wr0, st0;

    repeat (5) @(negedge clk);
    chk("R1 reset sdaOe", sdaOe, 0);
    chk("R1 reset wrValid", wrValid, 0);
    chk("R1 reset rdEn", rdEn, 0);
    rstN = 1'b1;
    repeat (5) @(negedge clk);

    // random and sequential reads from the table
    for (int v = 0; v < 5; v++) begin
      logic [15:0] a;
      int n;
      a = RD_TABLE[v][19:4];
      n = int'(RD_TABLE[v][3:0]);
      busStart();
      sendByte(DEV_W, ack); chk("R8 dev write ack", ack, 1);
      sendByte(a[15:8], ack); chk("R8 addr hi ack", ack, 1);
      sendByte(a[7:0], ack);  chk("R8 addr lo ack", ack, 1);
      busStart();
      sendByte(DEV_R, ack); chk("R8 dev read ack", ack, 1);
      for (int k = 0; k < n; k++) begin
        recvByte(k != n - 1, b);
        chk((a + 16'(k) == 16'h0000) ? "R10 wrap byte" : "R9 seq byte", b, memByte(a + 16'(k)));
      end
      spareClock(lvl); chk("R9 line free after nack", lvl, 1);
      busStop();
    end

    // page write with wrap
    wr0 = wrCnt; st0 = stopCnt;
    busStart();
    sendByte(DEV_W, ack); chk("R2 dev ack", ack, 1);
    sendByte(8'h12, ack); chk("R4 addr hi ack", ack, 1);
    sendByte(8'h7E, ack); chk("R4 addr lo ack", ack, 1);
    sendByte(8'h11, ack); chk("R4 data ack", ack, 1);
    sendByte(8'h22, ack); chk("R4 data ack", ack, 1);
    sendByte(8'h33, ack); chk("R4 data ack", ack, 1);
    chk("R6 no pulse before stop", stopCnt - st0, 0);
    busStop();
    repeat (4) @(negedge clk);
    chk("R4 byte count", wrCnt - wr0, 3);
    chk("R4 data0", logData[wr0], 8'h11);
    chk("R4 addr0", logAddr[wr0], 16'h127E);
    chk("R5 addr1", logAddr[wr0+1], 16'h127F);
    chk("R5 page wrap addr2", logAddr[wr0+2], 16'h1200);
    chk("R4 data2", logData[wr0+2], 8'h33);
    chk("R6 stop pulse", stopCnt - st0, 1);

    // current-address reads
    busStart();
    sendByte(DEV_R, ack); chk("R7 dev read ack", ack, 1);
    recvByte(1'b0, b); chk("R7 current read", b, memByte(16'h1201));
    busStop();
    busStart();
    sendByte(DEV_R, ack);
    recvByte(1'b0, b); chk("R7 pointer persists", b, memByte(16'h1202));
    busStop();
    chk("R6 no pulse after read", stopCnt - st0, 1);

    // address mismatches
    busStart();
    sendByte(8'hA2, ack); chk("R3 strap mismatch nack", ack, 0);
    sendByte(8'h00, ack); chk("R3 ignored after mismatch", ack, 0);
    busStop();
    busStart();
    sendByte(8'hBA, ack); chk("R3 prefix mismatch nack", ack, 0);
    busStop();

    // busy polling
    busy = 1'b1;
    busStart();
    sendByte(DEV_R, ack); chk("R11 no ack while busy", ack, 0);
    busStop();
    busy = 1'b0;
    busStart();
    sendByte(DEV_R, ack); chk("R11 ack after busy", ack, 1);
    recvByte(1'b0, b); chk("R11 read after busy", b, memByte(16'h1203));
    busStop();

    // start in mid byte
    busStart();
    sendByte(DEV_W, ack);
    sendBits(8'hF0, 4);
    busStart();
    sendByte(DEV_R, ack); chk("R1 ack after mid-byte start", ack, 1);
    recvByte(1'b0, b); chk("R1 pointer kept", b, memByte(16'h1204));
    busStop();

    // address-only write then current read
    wr0 = wrCnt; st0 = stopCnt;
    busStart();
    sendByte(DEV_W, ack);
    sendByte(8'h55, ack);
    sendByte(8'h55, ack);
    busStop();
    repeat (4) @(negedge clk);
    chk("R6 no pulse without data", stopCnt - st0, 0);
    chk("R4 no byte without data", wrCnt - wr0, 0);
    busStart();
    sendByte(DEV_R, ack);
    recvByte(1'b0, b); chk("R7 read at loaded pointer", b, memByte(16'h5555));
    busStop();

    chk("R12 drive only with scl low", oeHighViol, 0);
    finishRun();
  end
endmodule